// File: doc/BRIEF.md
# Programmable Interrupt Controller with Vectoring

This block collects a bank of interrupt request lines, conditions each one on its own, and steers it to one of two processor-facing outputs: a critical request and a non-critical request. Every source line is first brought into the clock domain by a flop chain. It is then sensed either as a level or as an edge, with a per-source polarity. An edge is latched in a sticky status bit until software clears it. A level status bit simply tracks the line.

Software reaches the block through a 32-bit register port, where a write takes effect on the clock edge and a read is combinational. Through this port it sets the enables, the class of each source, the sense mode and the polarity. It can read both the unfiltered status and the status after the enable mask. An optional vector generator picks the winning pending critical source, with a selectable priority direction. It then presents a handler address: a programmable base plus the winner's index shifted left by a programmable amount. Critical and non-critical sources may be placed in any mix of bit positions.

Top module: `irqc_top`

## Requirements
- R1: Word addresses are decoded as follows. 0 is raw status, 1 is masked status (read-only), 2 is enable, 3 is critical select, 4 is mode (1 = edge), 5 is polarity, 6 is vector control, 7 is vector base, and 8 is the vector (read-only). Writable registers read back what was written. Vector control keeps only bits [4:0]. Writes to addresses 1 and 8 change no register.
- R2: In level mode, a raw status bit equals the synchronized input XOR the polarity bit (polarity 1 means active-low). Writing 1 to that bit at address 0 does not clear it while the input stays active.
- R3: In edge mode, a raw status bit is set by a rising edge (polarity 0) or a falling edge (polarity 1), and it stays set after the line returns. Writing 1 to that bit at address 0 clears it. Writing 0 leaves it unchanged.
- R4: Masked status equals raw status AND enable.
- R5: The critical output is the OR of the masked status ANDed with critical select. The non-critical output is the OR of the masked status ANDed with the inverse of critical select. Both outputs are registered.
- R6: Vector control bit 0 enables the vector, and bits [4:2] hold a shift of 0 to 7. When the vector is enabled and an enabled critical source is pending, the vector equals base + (winner index << shift).
- R7: Vector control bit 1 sets the priority direction. With 0, the lowest pending index wins. With 1, the highest pending index wins.
- R8: When the vector is enabled and no enabled critical source is pending, the vector reads as the base, even when non-critical sources are pending. When the vector is disabled, it reads as 0.
- R9: If an edge is captured in the same cycle as a write-1 clear of that bit, the bit ends up set.
- R10: After reset, every register, both status registers, the vector and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Asynchronous interrupt request lines |
| regAddr | input | 4 | Register word address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register read data (combinational) |
| critIrq | output | 1 | Critical interrupt request |
| nonCritIrq | output | 1 | Non-critical interrupt request |

## Verification
Two functions can meet in a single cycle: the edge capture of a source and a software write-1 clear of the same status bit. The bench provokes this by counting clock edges through the synchronizer. It lands the clear write exactly on the edge where the detected edge loads the status bit, then reads the bit back and expects it set. Around that case, the bench sweeps every source position through both sense modes and both polarities. It also sweeps all eight shifts and both priority directions over several source pairs, and compares each result against addresses and output levels it computes arithmetically.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW    = 4'd0,
    REG_MASKED = 4'd1,
    REG_ENABLE = 4'd2,
    REG_CRIT   = 4'd3,
    REG_MODE   = 4'd4,
    REG_POL    = 4'd5,
    REG_VCTRL  = 4'd6,
    REG_VBASE  = 4'd7,
    REG_VECTOR = 4'd8
  } regSel_e;

  // strobes and vector settings handed from control to datapath
  typedef struct packed {
    logic       clrStrobe;
    logic       vecEn;
    logic       prioHigh;
    logic [2:0] shift;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    wrEn,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [NUM_SRC-1:0]      rawStatus,
  input  logic [NUM_SRC-1:0]      maskedStatus,
  input  logic [DATA_W-1:0]       vectorQ,
  output logic [DATA_W-1:0]       rdData,
  output logic [NUM_SRC-1:0]      enableQ,
  output logic [NUM_SRC-1:0]      critQ,
  output logic [NUM_SRC-1:0]      modeQ,
  output logic [NUM_SRC-1:0]      polQ,
  output logic [DATA_W-1:0]       baseQ,
  output ctrlStrobe_t             strb
);

  logic       vecEnQ;
  logic       prioHighQ;
  logic [2:0] shiftQ;
  regSel_e    sel;

  assign sel = regSel_e'(regAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      critQ     <= '0;
      modeQ     <= '0;
      polQ      <= '0;
      baseQ     <= '0;
      vecEnQ    <= 1'b0;
      prioHighQ <= 1'b0;
      shiftQ    <= '0;
    end else if (wrEn) begin
      case (sel)
        REG_ENABLE: enableQ <= wrData[NUM_SRC-1:0];
        REG_CRIT:   critQ   <= wrData[NUM_SRC-1:0];
        REG_MODE:   modeQ   <= wrData[NUM_SRC-1:0];
        REG_POL:    polQ    <= wrData[NUM_SRC-1:0];
        REG_VBASE:  baseQ   <= wrData;
        REG_VCTRL: begin
          vecEnQ    <= wrData[0];
          prioHighQ <= wrData[1];
          shiftQ    <= wrData[4:2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clrStrobe = wrEn && (sel == REG_RAW);
    strb.vecEn     = vecEnQ;
    strb.prioHigh  = prioHighQ;
    strb.shift     = shiftQ;
  end

  always_comb begin
    case (sel)
      REG_RAW:    rdData = DATA_W'(rawStatus);
      REG_MASKED: rdData = DATA_W'(maskedStatus);
      REG_ENABLE: rdData = DATA_W'(enableQ);
      REG_CRIT:   rdData = DATA_W'(critQ);
      REG_MODE:   rdData = DATA_W'(modeQ);
      REG_POL:    rdData = DATA_W'(polQ);
      REG_VCTRL:  rdData = DATA_W'({shiftQ, prioHighQ, vecEnQ});
      REG_VBASE:  rdData = baseQ;
      REG_VECTOR: rdData = vectorQ;
      default:    rdData = '0;
    endcase
  end

  // R1: a config write lands on the next edge
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == REG_ENABLE) |=> (enableQ == $past(wrData[NUM_SRC-1:0])));

  // R1: read-only addresses leave the configuration alone
  p_ro_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sel == REG_VECTOR || sel == REG_MASKED)) |=>
      ($stable(baseQ) && $stable(enableQ) && $stable(critQ) && $stable(modeQ)));

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] enableQ,
  input  logic [NUM_SRC-1:0] critQ,
  input  logic [NUM_SRC-1:0] modeQ,
  input  logic [NUM_SRC-1:0] polQ,
  input  logic [DATA_W-1:0]  baseQ,
  input  logic [DATA_W-1:0]  wrData,
  input  ctrlStrobe_t        strb,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic [DATA_W-1:0]  vectorQ,
  output logic               critIrq,
  output logic               nonCritIrq
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] polIn, prevQ, edgeHit, clrBits;
  logic [NUM_SRC-1:0] statusQ, statusNext;
  logic [NUM_SRC-1:0] critHits, nonCritHits;
  logic [IDX_W-1:0]   winIdx;
  logic [DATA_W-1:0]  vectorNext;

  // synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign polIn   = syncQ[SYNC_STAGES-1] ^ polQ;
  assign edgeHit = polIn & ~prevQ;
  assign clrBits = strb.clrStrobe ? wrData[NUM_SRC-1:0] : '0;

  // edge bits: capture beats clear; level bits: follow the line
  assign statusNext = (modeQ & ((statusQ & ~clrBits) | edgeHit)) | (~modeQ & polIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
    end else begin
      prevQ   <= polIn;
      statusQ <= statusNext;
    end
  end

  assign rawStatus    = statusQ;
  assign maskedStatus = statusQ & enableQ;
  assign critHits     = maskedStatus & critQ;
  assign nonCritHits  = maskedStatus & ~critQ;

  // priority pick over pending critical sources
  always_comb begin
    winIdx = '0;
    if (!strb.prioHigh) begin
      for (int i = NUM_SRC - 1; i >= 0; i--)
        if (critHits[i]) winIdx = IDX_W'(i);
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (critHits[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    if (!strb.vecEn)
      vectorNext = '0;
    else if (|critHits)
      vectorNext = baseQ + (DATA_W'(winIdx) << strb.shift);
    else
      vectorNext = baseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critIrq    <= 1'b0;
      nonCritIrq <= 1'b0;
      vectorQ    <= '0;
    end else begin
      critIrq    <= |critHits;
      nonCritIrq <= |nonCritHits;
      vectorQ    <= vectorNext;
    end
  end

  // R3: an uncleared edge bit stays set
  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusQ & modeQ & ~clrBits) & ~statusQ) == '0));

  // R2: an active level bit survives any clear
  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(~modeQ & polIn) & ~statusQ) == '0));

  // R9: capture and clear together leave the bit set
  p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(modeQ & edgeHit & clrBits) & ~statusQ) == '0));

  // R5: each request output has a pending source of its class behind it
  p_crit_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    critIrq |-> $past(|(statusQ & enableQ & critQ)));
  p_noncrit_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    nonCritIrq |-> $past(|(statusQ & enableQ & ~critQ)));

  // R8: a disabled vector reads zero
  p_vec_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.vecEn |=> (vectorQ == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [3:0]         regAddr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               critIrq,
  output logic               nonCritIrq
);

  logic [NUM_SRC-1:0] rawStatus, maskedStatus;
  logic [NUM_SRC-1:0] enableQ, critQ, modeQ, polQ;
  logic [DATA_W-1:0]  baseQ, vectorQ;
  ctrlStrobe_t        strb;

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .vectorQ(vectorQ),
    .rdData(rdData), .enableQ(enableQ), .critQ(critQ), .modeQ(modeQ),
    .polQ(polQ), .baseQ(baseQ), .strb(strb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .enableQ(enableQ), .critQ(critQ),
    .modeQ(modeQ), .polQ(polQ), .baseQ(baseQ), .wrData(wrData), .strb(strb),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .vectorQ(vectorQ),
    .critIrq(critIrq), .nonCritIrq(nonCritIrq)
  );

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] irqIn = '0;
  logic [3:0]    regAddr = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          critIrq, nonCritIrq;

  int checks = 0;
  int fails = 0;

  irqc_top u_irqc_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .critIrq(critIrq), .nonCritIrq(nonCritIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] enMask, critSel, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    for (int a = 0; a <= 8; a++) begin
      regRead(4'(a), rd);
      check("R10 reset register", rd, 32'h0);
    end
    check("R10 reset crit", {31'b0, critIrq}, 32'h0);
    check("R10 reset noncrit", {31'b0, nonCritIrq}, 32'h0);

    // R1: readback and read-only addresses
    regWrite(4'd2, 32'hDEAD_BEEF); regRead(4'd2, rd); check("R1 enable rb", rd, 32'hDEAD_BEEF);
    regWrite(4'd3, 32'h1234_5678); regRead(4'd3, rd); check("R1 crit rb", rd, 32'h1234_5678);
    regWrite(4'd4, 32'h0F0F_0F0F); regRead(4'd4, rd); check("R1 mode rb", rd, 32'h0F0F_0F0F);
    regWrite(4'd5, 32'hA0A0_0505); regRead(4'd5, rd); check("R1 pol rb", rd, 32'hA0A0_0505);
    regWrite(4'd7, 32'hCAFE_0000); regRead(4'd7, rd); check("R1 base rb", rd, 32'hCAFE_0000);
    regWrite(4'd6, 32'hFFFF_FFFF); regRead(4'd6, rd); check("R1 vctrl rb", rd, 32'h0000_001F);
    regWrite(4'd8, 32'h5555_5555); regWrite(4'd1, 32'h7777_7777);
    regRead(4'd2, rd); check("R1 ro enable", rd, 32'hDEAD_BEEF);
    regRead(4'd7, rd); check("R1 ro base", rd, 32'hCAFE_0000);
    regRead(4'd4, rd); check("R1 ro mode", rd, 32'h0F0F_0F0F);

    // R2 R4 R5: level sweep, both polarities
    enMask = 32'hF0F0_A5A5; critSel = 32'h3C3C_9669;
    regWrite(4'd6, 32'h0); regWrite(4'd4, 32'h0);
    regWrite(4'd2, enMask); regWrite(4'd3, critSel);
    for (int p = 0; p < 2; p++) begin
      regWrite(4'd5, p ? 32'hFFFF_FFFF : 32'h0);
      for (int b = 0; b < NS; b++) begin
        logic [31:0] one;
        one = 32'h1 << b;
        @(negedge clk); irqIn = p ? ~one : one;
        settle();
        regRead(4'd0, rd); check("R2 level raw", rd, one);
        regRead(4'd1, rd); check("R4 masked", rd, one & enMask);
        check("R5 crit out", {31'b0, critIrq}, {31'b0, |(one & enMask & critSel)});
        check("R5 noncrit out", {31'b0, nonCritIrq}, {31'b0, |(one & enMask & ~critSel)});
        regWrite(4'd0, one); settle();
        regRead(4'd0, rd); check("R2 level no clear", rd, one);
      end
      @(negedge clk); irqIn = p ? '1 : '0;
      settle();
    end

    // R3: edge sweep, rising then falling
    regWrite(4'd5, 32'h0); @(negedge clk); irqIn = '0; settle();
    regWrite(4'd4, 32'hFFFF_FFFF); regWrite(4'd0, 32'hFFFF_FFFF); settle();
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin
        @(negedge clk); irqIn = '1; settle();
        regWrite(4'd5, 32'hFFFF_FFFF); settle();
        regWrite(4'd0, 32'hFFFF_FFFF); settle();
      end
      for (int b = 0; b < NS; b++) begin
        logic [31:0] one;
        one = 32'h1 << b;
        regRead(4'd0, rd); check("R3 edge idle", rd, 32'h0);
        @(negedge clk); irqIn = irqIn ^ one;
        repeat (2) @(negedge clk); irqIn = irqIn ^ one;
        settle();
        regRead(4'd0, rd); check("R3 edge sticky", rd, one);
        regWrite(4'd0, ~one); settle();
        regRead(4'd0, rd); check("R3 write0 keeps", rd, one);
        regWrite(4'd0, one); settle();
        regRead(4'd0, rd); check("R3 write1 clears", rd, 32'h0);
      end
    end

    // R9: edge capture meets clear in the same cycle
    regWrite(4'd5, 32'h0); @(negedge clk); irqIn = '0; settle();
    regWrite(4'd0, 32'hFFFF_FFFF); settle();
    @(negedge clk); irqIn = 32'h0000_0100;
    @(negedge clk);
    @(negedge clk); regAddr = 4'd0; wrData = 32'h0000_0100; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    settle();
    regRead(4'd0, rd); check("R9 capture beats clear", rd, 32'h0000_0100);
    @(negedge clk); irqIn = '0; settle();

    // R6 R7: vector sweep over shift, direction and source pairs
    base = 32'h8000_0100;
    regWrite(4'd4, 32'h0); regWrite(4'd5, 32'h0);
    regWrite(4'd2, 32'hFFFF_FFFF); regWrite(4'd3, 32'hFFFF_FFFF);
    regWrite(4'd7, base);
    for (int k = 0; k < 4; k++) begin
      int lo, hi;
      lo = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 12 : 30;
      hi = (k == 0) ? 31 : (k == 1) ? 17 : (k == 2) ? 13 : 31;
      @(negedge clk); irqIn = (32'h1 << lo) | (32'h1 << hi);
      for (int sh = 0; sh < 8; sh++) begin
        for (int d = 0; d < 2; d++) begin
          regWrite(4'd6, 32'((sh << 2) | (d << 1) | 1));
          settle();
          regRead(4'd8, rd);
          check(d ? "R7 high-first vector" : "R6 low-first vector", rd,
                base + (32'(d ? hi : lo) << sh));
        end
      end
    end

    // R4 R6: masked-off winner is skipped
    regWrite(4'd6, 32'h1 | (3 << 2)); regWrite(4'd2, ~(32'h1 << 30)); settle();
    regRead(4'd8, rd); check("R6 masked winner skipped", rd, base + (32'd31 << 3));

    // R8: only non-critical pending, nothing pending, vector off
    regWrite(4'd2, 32'hFFFF_FFFF); regWrite(4'd3, 32'h0); settle();
    regRead(4'd8, rd); check("R8 noncrit only base", rd, base);
    check("R8 crit low", {31'b0, critIrq}, 32'h0);
    check("R8 noncrit high", {31'b0, nonCritIrq}, 32'h1);
    regWrite(4'd3, 32'hFFFF_FFFF); @(negedge clk); irqIn = '0; settle();
    regRead(4'd8, rd); check("R8 idle base", rd, base);
    @(negedge clk); irqIn = 32'h0000_0010; regWrite(4'd6, 32'h0); settle();
    regRead(4'd8, rd); check("R8 disabled zero", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule